// File: doc/BRIEF.md
# Hypercube Recursive-Doubling Broadcaster

This block models eight processing nodes joined as a three-dimensional binary cube. Every node has a three-bit label, a word register and an informed flag. There is one link per dimension, and it joins each node to the node whose label differs from its own in that single bit. A single word enters at node 000. The word then spreads by recursive doubling: in each phase, every node that already holds the word copies it across one dimension. The number of holders therefore doubles each phase, and the whole cube holds the word after log2 of the node count phases.

The transfer time is modelled explicitly. A phase lasts a fixed startup time plus a per-word time multiplied by the message length, all counted in clock cycles and set by parameters. The transfers of a phase all land together on the last cycle of that phase. The next dimension is used only after that cycle.

The input word arrives on a valid/ready channel. `msg_ready` is high only while no broadcast is running. A word is taken on a clock edge where `msg_valid` and `msg_ready` are both high. The sender may hold `msg_valid` as long as it likes, and nothing is taken while `msg_ready` is low, so a word offered during a broadcast is simply not consumed. The per-node words, the informed flags and a one-cycle `done` strobe are plain outputs.

Top module: `hc_bcast_top`

## Requirements
- R1: After reset every informed flag is 0, every node word is 0, `done` is 0 and `msg_ready` is 1.
- R2: On an edge where `msg_valid` and `msg_ready` are both 1, node 0 takes `msg_data` and sets its informed flag. All other informed flags are cleared on that same edge.
- R3: `msg_ready` is 0 from the accepting edge until the final transfer edge. A word offered while `msg_ready` is 0 changes no node word.
- R4: Each phase lasts PH_LEN = TS_CYC + TW_CYC*MSG_WORDS cycles, with a default of 7. Informed flags and node words change only on the last edge of a phase.
- R5: Phase k (k = 0, 1, 2) uses dimension k. An informed node whose label has bit k clear copies its word to the node whose label is its own with bit k set. The informed count reads 1, 2, 4 and 8 after 0, 1, 2 and 3 phases.
- R6: Informed flags never drop during a broadcast, and a sender keeps its own word.
- R7: After the third phase, all eight node words equal the accepted word and all eight informed flags are 1.
- R8: `done` is 1 for exactly one cycle, namely the cycle right after the final transfer edge. In that cycle `msg_ready` is already 1.
- R9: A word held valid through a broadcast is accepted on the edge that ends the `done` cycle, and that acceptance starts a new broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Broadcast word offered |
| msg_ready | output | 1 | Block idle, word can be taken |
| msg_data | input | DATA_W | Word to broadcast |
| node_data | output | NODES*DATA_W | Node n's word in bits [n*DATA_W +: DATA_W] |
| node_informed | output | NODES | Bit n set when node n holds the current word |
| done | output | 1 | One-cycle strobe after the final phase |

## Verification
A wrong dimension counter or a wrong link index shows up at the first transfer edge that uses it. In that case the informed-flag vector holds the wrong set of nodes, or a node holds a word other than the one sent, and this can be seen no more than one phase after the fault. A phase timer that is off by even one cycle moves the flag changes by one clock, and a comparison made on every cycle catches this directly. A fault in the ready or done logic appears as an accepted stray word, which corrupts node 0, or as a `done` strobe that is missing or lasts too long.

// File: rtl/hc_bcast_pkg.sv
package hc_bcast_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} hc_state_e;

  function automatic int unsigned phase_len(input int unsigned ts, input int unsigned tw,
                                            input int unsigned words);
    int unsigned len;
    len = ts + tw * words;
    return (len == 0) ? 1 : len;
  endfunction

  function automatic int unsigned safe_clog2(input int unsigned v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction
endpackage

// File: rtl/hc_phase_timer.sv
module hc_phase_timer #(
  parameter int unsigned LEN = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic last
);
  localparam int unsigned CNT_W = hc_bcast_pkg::safe_clog2(LEN);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(LEN - 1);

  logic [CNT_W-1:0] cnt_q;

  assign last = run && (cnt_q == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= (cnt_q == TOP) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/hc_sched.sv
module hc_sched
  import hc_bcast_pkg::*;
#(
  parameter int unsigned DIMS  = 3,
  parameter int unsigned DIM_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             offer,
  input  logic             phase_last,
  output logic             ready,
  output logic             accept,
  output logic             running,
  output logic             commit,
  output logic [DIM_W-1:0] dim,
  output logic             done
);
  localparam logic [DIM_W-1:0] LAST_DIM = DIM_W'(DIMS - 1);

  hc_state_e        state_q;
  logic [DIM_W-1:0] dim_q;
  logic             done_q;

  assign ready   = (state_q == ST_IDLE);
  assign running = (state_q == ST_RUN);
  assign accept  = ready && offer;
  assign commit  = running && phase_last;
  assign dim     = dim_q;
  assign done    = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dim_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        state_q <= ST_RUN;
        dim_q   <= '0;
      end else if (commit) begin
        if (dim_q == LAST_DIM) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end else begin
          dim_q <= dim_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hc_node.sv
module hc_node #(
  parameter int unsigned ID     = 0,
  parameter int unsigned DIMS   = 3,
  parameter int unsigned DIM_W  = 2,
  parameter int unsigned DATA_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       accept,
  input  logic [DATA_W-1:0]          src_word,
  input  logic                       commit,
  input  logic [DIM_W-1:0]           dim,
  input  logic [DIMS-1:0][DATA_W-1:0] nbr_data,
  input  logic [DIMS-1:0]            nbr_inf,
  output logic [DATA_W-1:0]          data,
  output logic                       informed
);
  localparam logic [DIMS-1:0] LABEL = DIMS'(ID);

  logic [DATA_W-1:0] data_q;
  logic              inf_q;
  logic              take;

  assign take     = commit && LABEL[dim] && nbr_inf[dim] && !inf_q;
  assign data     = data_q;
  assign informed = inf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      inf_q  <= 1'b0;
    end else if (accept) begin
      if (ID == 0) begin
        data_q <= src_word;
        inf_q  <= 1'b1;
      end else begin
        inf_q <= 1'b0;
      end
    end else if (take) begin
      data_q <= nbr_data[dim];
      inf_q  <= 1'b1;
    end
  end
endmodule

// File: rtl/hc_bcast_top.sv
module hc_bcast_top #(
  parameter int unsigned DIMS      = 3,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned TS_CYC    = 3,
  parameter int unsigned TW_CYC    = 2,
  parameter int unsigned MSG_WORDS = 2,
  localparam int unsigned NODES    = 1 << DIMS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     msg_valid,
  output logic                     msg_ready,
  input  logic [DATA_W-1:0]        msg_data,
  output logic [NODES*DATA_W-1:0]  node_data,
  output logic [NODES-1:0]         node_informed,
  output logic                     done
);
  localparam int unsigned PH_LEN = hc_bcast_pkg::phase_len(TS_CYC, TW_CYC, MSG_WORDS);
  localparam int unsigned DIM_W  = hc_bcast_pkg::safe_clog2(DIMS);

  logic             accept, running, commit, phase_last;
  logic [DIM_W-1:0] dim;
  logic [DATA_W-1:0] word_q [NODES];
  logic [NODES-1:0]  inf_q;

  hc_sched #(.DIMS(DIMS), .DIM_W(DIM_W)) u_sched (
    .clk(clk), .rst_n(rst_n), .offer(msg_valid), .phase_last(phase_last),
    .ready(msg_ready), .accept(accept), .running(running), .commit(commit),
    .dim(dim), .done(done)
  );

  hc_phase_timer #(.LEN(PH_LEN)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(accept), .run(running), .last(phase_last)
  );

  for (genvar n = 0; n < NODES; n++) begin : g_node
    logic [DIMS-1:0][DATA_W-1:0] link_data;
    logic [DIMS-1:0]             link_inf;

    for (genvar d = 0; d < DIMS; d++) begin : g_link
      assign link_data[d] = word_q[n ^ (1 << d)];
      assign link_inf[d]  = inf_q[n ^ (1 << d)];
    end

    hc_node #(.ID(n), .DIMS(DIMS), .DIM_W(DIM_W), .DATA_W(DATA_W)) u_node (
      .clk(clk), .rst_n(rst_n), .accept(accept), .src_word(msg_data),
      .commit(commit), .dim(dim), .nbr_data(link_data), .nbr_inf(link_inf),
      .data(word_q[n]), .informed(inf_q[n])
    );

    assign node_data[n*DATA_W +: DATA_W] = word_q[n];
  end

  assign node_informed = inf_q;
endmodule

// File: rtl/hc_bcast_chk.sv
module hc_bcast_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NODES  = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    msg_valid,
  input logic                    msg_ready,
  input logic [NODES*DATA_W-1:0] node_data,
  input logic [NODES-1:0]        node_informed,
  input logic                    done
);
  // R2
  accept_seeds_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready) |=> (node_informed == NODES'(1)));

  // R3
  busy_source_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_ready |=> $stable(node_data[DATA_W-1:0]));

  // R5
  count_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0($countones(node_informed)));

  // R6
  flags_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_ready |=> ((node_informed & $past(node_informed)) == $past(node_informed)));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_all_informed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (&node_informed && msg_ready));
endmodule

bind hc_bcast_top hc_bcast_chk #(.DATA_W(DATA_W), .NODES(NODES)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .node_data(node_data), .node_informed(node_informed), .done(done)
);

// File: tb/test_hc_bcast_top.sv
`timescale 1ns/1ps
module test_hc_bcast_top;
  localparam int DW = 16;
  localparam int N  = 8;
  localparam int L  = 3 + 2 * 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic msg_valid = 1'b0;
  logic [DW-1:0] msg_data = '0;
  logic msg_ready, done;
  logic [N*DW-1:0] node_data;
  logic [N-1:0] node_informed;

  int vectors = 0;
  int fails = 0;
  bit cmp_on = 1'b0;

  always #4 clk = ~clk;

  hc_bcast_top i_hc_bcast_top (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_data(msg_data), .node_data(node_data), .node_informed(node_informed),
    .done(done)
  );

  // behavioural reference
  logic [DW-1:0] m_data [N];
  bit m_inf [N];
  bit m_busy, m_done;
  int m_dim, m_tmr;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_data[i] = '0; m_inf[i] = 0; end
      m_busy = 0; m_done = 0; m_dim = 0; m_tmr = 0;
    end else begin
      m_done = 0;
      if (!m_busy && msg_valid) begin
        m_busy = 1; m_dim = 0; m_tmr = 0;
        for (int i = 1; i < N; i++) m_inf[i] = 0;
        m_inf[0] = 1; m_data[0] = msg_data;
      end else if (m_busy) begin
        if (m_tmr == L - 1) begin
          m_tmr = 0;
          for (int i = 0; i < N; i++)
            if (((i >> m_dim) & 1) == 1 && m_inf[i ^ (1 << m_dim)] && !m_inf[i]) begin
              m_data[i] = m_data[i ^ (1 << m_dim)];
              m_inf[i] = 1;
            end
          if (m_dim == 2) begin m_busy = 0; m_done = 1; end
          else m_dim++;
        end else m_tmr++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      logic [N-1:0] ei;
      logic [N*DW-1:0] ed;
      for (int i = 0; i < N; i++) begin ei[i] = m_inf[i]; ed[i*DW +: DW] = m_data[i]; end
      check(msg_ready == !m_busy, "R3 ready", 128'(msg_ready), 128'(!m_busy));
      check(done == m_done, "R8 done", 128'(done), 128'(m_done));
      check(node_informed == ei, "R4,R5 flags", 128'(node_informed), 128'(ei));
      check(node_data == ed, "R6 words", node_data, ed);
    end
  end

  // runs one broadcast with checks at each phase boundary; keep_valid leaves valid high
  task automatic run_bcast(input logic [DW-1:0] w, input bit poke, input bit keep_valid);
    @(negedge clk);
    msg_valid = 1'b1; msg_data = w;
    @(negedge clk);
    if (!keep_valid) msg_valid = 1'b0;
    for (int k = 0; k <= 3; k++) begin
      check($countones(node_informed) == (1 << k), "R5 count",
            128'($countones(node_informed)), 128'(1 << k));
      check(node_data[DW-1:0] == w, "R2 source", 128'(node_data[DW-1:0]), 128'(w));
      if (k == 3) break;
      if (poke && k == 1) begin
        msg_valid = 1'b1; msg_data = ~w;
        repeat (3) @(negedge clk);
        check(node_data[DW-1:0] == w, "R3 ignored", 128'(node_data[DW-1:0]), 128'(w));
        msg_valid = keep_valid;
        repeat (L - 3) @(negedge clk);
      end else begin
        repeat (L - 1) @(negedge clk);
        // R4: last cycle of the phase, flags unchanged
        check($countones(node_informed) == (1 << k), "R4 mid-phase",
              128'($countones(node_informed)), 128'(1 << k));
        @(negedge clk);
      end
    end
    check(done == 1'b1, "R8 strobe", 128'(done), 128'(1));
    check(msg_ready == 1'b1, "R8 ready", 128'(msg_ready), 128'(1));
    check(node_data == {N{w}}, "R7 all words", node_data, {N{w}});
    check(&node_informed, "R7 all flags", 128'(node_informed), 128'({N{1'b1}}));
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++;
        vectors++;
        $display("FAIL watchdog: actual %0d cycles expected under 100000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(node_informed == '0 && node_data == '0 && !done && msg_ready, "R1 reset",
          128'(node_informed), 128'(0));
    rst_n = 1'b1;
    cmp_on = 1'b1;
    @(negedge clk);
    run_bcast(16'hA5C3, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    run_bcast(16'h0001, 1'b1, 1'b0);
    run_bcast(16'hFFFF, 1'b0, 1'b0);
    // R9: word held valid across the done cycle starts the next broadcast at once
    msg_data = 16'h1234;
    @(negedge clk);
    msg_valid = 1'b1;
    @(negedge clk);
    msg_data = 16'h5678;
    repeat (3 * L) @(negedge clk);
    check(done == 1'b1, "R9 first done", 128'(done), 128'(1));
    @(negedge clk);
    msg_valid = 1'b0;
    check(node_informed == 8'h01, "R9 restart flags", 128'(node_informed), 128'(1));
    check(node_data[DW-1:0] == 16'h5678, "R9 restart word", 128'(node_data[DW-1:0]),
          128'(16'h5678));
    repeat (3 * L + 2) @(negedge clk);
    check(node_data == {N{16'h5678}}, "R7 after restart", node_data, {N{16'h5678}});
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule